// File: doc/BRIEF.md
# Static Memory Write-Cycle Timer

This block runs single write accesses to an external asynchronous static memory. An internal bus offers a write with address, data and byte enables. The block then drives the memory pins for a length of time set by timing inputs counted in clock cycles. The chip select and the write strobe each have their own setup, low-time and hold counts. An overall cycle length sets the minimum length of the access. A lane mode selects one of two pin styles. In select mode, one common write strobe is used and each byte lane has a byte-select pin. In byte-write mode, the strobe waveform is copied onto one write strobe per byte lane, and each lane's strobe is gated by its byte enable.

The request side is a valid/ready channel. The bus holds `req_valid` and the request fields stable until it sees `req_ready` at a rising clock edge. That edge is the handshake. `req_ready` is low for the whole access and for the one clock in which `done` is high, so back-pressure lasts L+1 cycles, where L is the access length. The timing inputs are sampled at the handshake edge. Changes to them during an access have no effect on that access. Every memory pin comes from a register, and all select and strobe pins are active low.

Top module: `smcw_write_timer`

## Requirements
- R1: `req_ready` is high only when no access is running and `done` is low. A request is taken on a rising edge with `req_valid` and `req_ready` both high. All timing inputs and the lane mode are captured on that edge, and later changes to them do not alter the running access.
- R2: Access cycles are numbered k = 0 .. L-1, where k = 0 is the first cycle after the handshake edge. From k = 0, `mem_addr` and `mem_data` show the captured request and stay stable until the access ends. `mem_data_oe` is high in exactly the L access cycles.
- R3: Let WS, WP and WH be the write strobe's setup, low-time and hold counts, and let WPe = max(WP,1). In select mode, `mem_we_n` is low exactly in the access cycles with WS <= k < WS+WPe, and high at all other times.
- R4: Let CS, CP and CH be the chip select's setup, low-time and hold counts, and let CPe = max(CP,1). `mem_cs_n` is low exactly in the access cycles with CS <= k < CS+CPe. This is independent of the write strobe counts.
- R5: Lane mode 1 is byte-write mode. In this mode, `mem_wr_n[i]` is low exactly when the R3 window is active and captured enable bit i is 1. `mem_we_n` and all `mem_bs_n` stay high. Lane mode 0 is select mode. In this mode, all `mem_wr_n` stay high and `mem_bs_n[i]` equals the inverse of captured enable bit i during the access. Lane i covers data bits 8i+7..8i.
- R6: The access length is L = max(cycle length, WS+WPe+WH, CS+CPe+CH). A cycle length shorter than either sum never cuts a hold short.
- R7: `done` is high for exactly one clock, in cycle k = L. `req_ready` returns high in cycle k = L+1.
- R8: After reset and whenever no access runs, all select and strobe pins are high, and `mem_data_oe` and `done` are low.
- R9: A request held valid during an access is not taken. `mem_addr` keeps the running access's address until that request is accepted after `done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all timing counts are in its cycles |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Write request offered |
| req_ready | output | 1 | Block can take a request |
| req_addr | input | AW | Write address |
| req_data | input | DW | Write data |
| req_be | input | DW/8 | Byte enables, bit i for lane i |
| cfg_we_setup | input | TW | Write strobe setup count |
| cfg_we_pulse | input | TW | Write strobe low count (0 acts as 1) |
| cfg_we_hold | input | TW | Write strobe hold count |
| cfg_cs_setup | input | TW | Chip select setup count |
| cfg_cs_pulse | input | TW | Chip select low count (0 acts as 1) |
| cfg_cs_hold | input | TW | Chip select hold count |
| cfg_cycle | input | TW+2 | Minimum access length |
| cfg_byte_mode | input | 1 | 1 = byte-write strobes, 0 = common strobe with byte selects |
| mem_addr | output | AW | Memory address bus |
| mem_data | output | DW | Memory write data |
| mem_data_oe | output | 1 | Data bus drive enable |
| mem_cs_n | output | 1 | Chip select, active low |
| mem_we_n | output | 1 | Common write strobe, active low |
| mem_wr_n | output | DW/8 | Per-lane write strobes, active low |
| mem_bs_n | output | DW/8 | Per-lane byte selects, active low |
| done | output | 1 | One-clock end-of-access pulse |

## Verification
The embedded assertions check properties that must hold on every cycle:
- Pins stay quiet whenever the data bus is not driven.
- Address and data stay stable across the access.
- The common strobe and the lane strobes are never active together.
- `done` is a single pulse that clears `busy` and holds off ready.
- The captured length stays frozen while busy.

Some behaviour can only be shown by the bench's sweep over every setup, low-time and hold value from 0 to 2 for both signals, with several cycle lengths. This covers the exact cycle in which each edge falls, the treatment of a zero low-time, the stretching of a short cycle length, byte-lane gating, and the rejection of a request held during an access.

// File: rtl/smcw_pkg.sv
package smcw_pkg;
  // Pin style for the byte lanes.
  typedef enum logic {
    LANE_SELECT = 1'b0,
    LANE_WRITE  = 1'b1
  } lane_mode_e;
endpackage

// File: rtl/smcw_window.sv
// One setup/low/hold phase generator. It reports whether the access
// position lies in the low window, and the total span of the phases.
module smcw_window #(
  parameter int TW = 4,
  parameter int CW = TW + 2
) (
  input  logic [CW-1:0] pos,
  input  logic [TW-1:0] setup,
  input  logic [TW-1:0] pulse,
  input  logic [TW-1:0] hold,
  output logic          active,
  output logic [CW-1:0] span
);
  logic [CW-1:0] s_w, p_w, h_w, rise_w;

  always_comb begin
    s_w    = CW'(setup);
    p_w    = (pulse == '0) ? CW'(1) : CW'(pulse);
    h_w    = CW'(hold);
    rise_w = s_w + p_w;
    span   = rise_w + h_w;
    active = (pos >= s_w) && (pos < rise_w);
  end
endmodule

// File: rtl/smcw_seq.sv
// Access sequencer: handshake, position counter and end pulse.
module smcw_seq #(
  parameter int CW = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  input  logic [CW-1:0] len,
  output logic          req_ready,
  output logic          start,
  output logic          busy,
  output logic          busy_nxt,
  output logic [CW-1:0] cnt,
  output logic [CW-1:0] cnt_nxt,
  output logic          done
);
  logic last;

  always_comb begin
    req_ready = !busy && !done;
    start     = req_valid && req_ready;
    last      = busy && (cnt == len - CW'(1));
    if (start) begin
      busy_nxt = 1'b1;
      cnt_nxt  = '0;
    end else if (last) begin
      busy_nxt = 1'b0;
      cnt_nxt  = '0;
    end else begin
      busy_nxt = busy;
      cnt_nxt  = busy ? cnt + CW'(1) : cnt;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0;
      cnt  <= '0;
      done <= 1'b0;
    end else begin
      busy <= busy_nxt;
      cnt  <= cnt_nxt;
      done <= last;
    end
  end

  p_done_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  p_end_gap_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> (done && !req_ready));
  p_start_on_valid_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(req_valid));
  p_count_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (cnt < len));
endmodule

// File: rtl/smcw_lanes.sv
// Strobe and byte-select registers for the two lane styles.
module smcw_lanes
  import smcw_pkg::*;
#(
  parameter int NL = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          busy_nxt,
  input  logic          strobe_nxt,
  input  lane_mode_e    mode_nxt,
  input  logic [NL-1:0] be_nxt,
  output logic          we_n,
  output logic [NL-1:0] wr_n,
  output logic [NL-1:0] bs_n
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) we_n <= 1'b1;
    else        we_n <= !(strobe_nxt && mode_nxt == LANE_SELECT);
  end

  for (genvar i = 0; i < NL; i++) begin : g_lane
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        wr_n[i] <= 1'b1;
        bs_n[i] <= 1'b1;
      end else begin
        wr_n[i] <= !(strobe_nxt && mode_nxt == LANE_WRITE && be_nxt[i]);
        bs_n[i] <= !(busy_nxt && mode_nxt == LANE_SELECT && be_nxt[i]);
      end
    end
  end

  p_style_excl_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !we_n |-> (&wr_n));
  p_wr_no_bs_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !(&wr_n) |-> (&bs_n));
endmodule

// File: rtl/smcw_write_timer.sv
// Static memory write-cycle timer (top).
module smcw_write_timer
  import smcw_pkg::*;
#(
  parameter int AW = 24,
  parameter int DW = 32,
  parameter int TW = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 req_valid,
  output logic                 req_ready,
  input  logic [AW-1:0]        req_addr,
  input  logic [DW-1:0]        req_data,
  input  logic [DW/8-1:0]      req_be,
  input  logic [TW-1:0]        cfg_we_setup,
  input  logic [TW-1:0]        cfg_we_pulse,
  input  logic [TW-1:0]        cfg_we_hold,
  input  logic [TW-1:0]        cfg_cs_setup,
  input  logic [TW-1:0]        cfg_cs_pulse,
  input  logic [TW-1:0]        cfg_cs_hold,
  input  logic [TW+1:0]        cfg_cycle,
  input  logic                 cfg_byte_mode,
  output logic [AW-1:0]        mem_addr,
  output logic [DW-1:0]        mem_data,
  output logic                 mem_data_oe,
  output logic                 mem_cs_n,
  output logic                 mem_we_n,
  output logic [DW/8-1:0]      mem_wr_n,
  output logic [DW/8-1:0]      mem_bs_n,
  output logic                 done
);
  localparam int NL = DW / 8;
  localparam int CW = TW + 2;

  // captured timing and request
  logic [TW-1:0] ws_q, wp_q, wh_q, cs_q, cp_q, ch_q;
  logic [CW-1:0] cyc_q;
  lane_mode_e    mode_q;
  logic [NL-1:0] be_q;
  logic [AW-1:0] addr_q;
  logic [DW-1:0] data_q;

  // effective values: live inputs on the handshake edge, captured otherwise
  logic [TW-1:0] ws_e, wp_e, wh_e, cs_e, cp_e, ch_e;
  logic [CW-1:0] cyc_e;
  lane_mode_e    mode_e;
  logic [NL-1:0] be_e;

  logic          start, busy, busy_nxt;
  logic [CW-1:0] cnt, cnt_nxt, len, we_span, cs_span;
  logic          we_act, cs_act;
  logic          cs_n_q, oe_q;

  always_comb begin
    ws_e   = start ? cfg_we_setup : ws_q;
    wp_e   = start ? cfg_we_pulse : wp_q;
    wh_e   = start ? cfg_we_hold  : wh_q;
    cs_e   = start ? cfg_cs_setup : cs_q;
    cp_e   = start ? cfg_cs_pulse : cp_q;
    ch_e   = start ? cfg_cs_hold  : ch_q;
    cyc_e  = start ? cfg_cycle    : cyc_q;
    mode_e = start ? lane_mode_e'(cfg_byte_mode) : mode_q;
    be_e   = start ? req_be       : be_q;
  end

  smcw_window #(.TW(TW), .CW(CW)) u_we_win (
    .pos(cnt_nxt), .setup(ws_e), .pulse(wp_e), .hold(wh_e),
    .active(we_act), .span(we_span));

  smcw_window #(.TW(TW), .CW(CW)) u_cs_win (
    .pos(cnt_nxt), .setup(cs_e), .pulse(cp_e), .hold(ch_e),
    .active(cs_act), .span(cs_span));

  always_comb begin
    len = cyc_e;
    if (we_span > len) len = we_span;
    if (cs_span > len) len = cs_span;
  end

  smcw_seq #(.CW(CW)) u_seq (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .len(len),
    .req_ready(req_ready), .start(start), .busy(busy),
    .busy_nxt(busy_nxt), .cnt(cnt), .cnt_nxt(cnt_nxt), .done(done));

  smcw_lanes #(.NL(NL)) u_lanes (
    .clk(clk), .rst_n(rst_n), .busy_nxt(busy_nxt),
    .strobe_nxt(busy_nxt && we_act), .mode_nxt(mode_e), .be_nxt(be_e),
    .we_n(mem_we_n), .wr_n(mem_wr_n), .bs_n(mem_bs_n));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ws_q <= '0; wp_q <= '0; wh_q <= '0;
      cs_q <= '0; cp_q <= '0; ch_q <= '0;
      cyc_q  <= '0;
      mode_q <= LANE_SELECT;
      be_q   <= '0;
      addr_q <= '0;
      data_q <= '0;
    end else if (start) begin
      ws_q <= cfg_we_setup; wp_q <= cfg_we_pulse; wh_q <= cfg_we_hold;
      cs_q <= cfg_cs_setup; cp_q <= cfg_cs_pulse; ch_q <= cfg_cs_hold;
      cyc_q  <= cfg_cycle;
      mode_q <= lane_mode_e'(cfg_byte_mode);
      be_q   <= req_be;
      addr_q <= req_addr;
      data_q <= req_data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cs_n_q <= 1'b1;
      oe_q   <= 1'b0;
    end else begin
      cs_n_q <= !(busy_nxt && cs_act);
      oe_q   <= busy_nxt;
    end
  end

  assign mem_addr    = addr_q;
  assign mem_data    = data_q;
  assign mem_cs_n    = cs_n_q;
  assign mem_data_oe = oe_q;

  p_idle_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_data_oe |-> (mem_cs_n && mem_we_n && (&mem_wr_n) && (&mem_bs_n)));
  p_bus_stable_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_data_oe && $past(mem_data_oe)) |-> ($stable(mem_addr) && $stable(mem_data)));
  p_strobe_inside_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_we_n |-> mem_data_oe);
  p_select_inside_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_cs_n |-> mem_data_oe);
  p_len_frozen_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable(len));
  p_no_take_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && req_valid) |=> $stable(mem_addr));
endmodule

// File: tb/smcw_write_timer_test.sv
module smcw_write_timer_test;
  localparam int AW = 24;
  localparam int DW = 32;
  localparam int TW = 4;
  localparam int NL = DW / 8;
  localparam int CW = TW + 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0;
  logic req_ready;
  logic [AW-1:0] req_addr = '0;
  logic [DW-1:0] req_data = '0;
  logic [NL-1:0] req_be = '0;
  logic [TW-1:0] cfg_we_setup = '0, cfg_we_pulse = '0, cfg_we_hold = '0;
  logic [TW-1:0] cfg_cs_setup = '0, cfg_cs_pulse = '0, cfg_cs_hold = '0;
  logic [CW-1:0] cfg_cycle = '0;
  logic cfg_byte_mode = 1'b0;
  logic [AW-1:0] mem_addr;
  logic [DW-1:0] mem_data;
  logic mem_data_oe, mem_cs_n, mem_we_n, done;
  logic [NL-1:0] mem_wr_n, mem_bs_n;

  int n_tests = 0;
  int n_fail = 0;

  always #2 clk = ~clk;

  smcw_write_timer #(.AW(AW), .DW(DW), .TW(TW)) uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_data(req_data), .req_be(req_be),
    .cfg_we_setup(cfg_we_setup), .cfg_we_pulse(cfg_we_pulse), .cfg_we_hold(cfg_we_hold),
    .cfg_cs_setup(cfg_cs_setup), .cfg_cs_pulse(cfg_cs_pulse), .cfg_cs_hold(cfg_cs_hold),
    .cfg_cycle(cfg_cycle), .cfg_byte_mode(cfg_byte_mode),
    .mem_addr(mem_addr), .mem_data(mem_data), .mem_data_oe(mem_data_oe),
    .mem_cs_n(mem_cs_n), .mem_we_n(mem_we_n), .mem_wr_n(mem_wr_n),
    .mem_bs_n(mem_bs_n), .done(done));

  task automatic chk(input bit ok, input string tag, input logic [63:0] act,
                     input logic [63:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s act=%0h exp=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic int pe(input int p);
    return (p == 0) ? 1 : p;
  endfunction

  task automatic run_access(input int ws, input int wp, input int wh,
                            input int cs, input int cp, input int ch,
                            input int cyc, input bit bm, input logic [NL-1:0] be,
                            input logic [AW-1:0] addr, input logic [DW-1:0] data,
                            input bit hv);
    int len, we_sum, cs_sum;
    bit wwin, cwin;
    logic [NL-1:0] exp_wr, exp_bs;
    we_sum = ws + pe(wp) + wh;
    cs_sum = cs + pe(cp) + ch;
    len = cyc;
    if (we_sum > len) len = we_sum;
    if (cs_sum > len) len = cs_sum;

    @(negedge clk);
    cfg_we_setup = TW'(ws); cfg_we_pulse = TW'(wp); cfg_we_hold = TW'(wh);
    cfg_cs_setup = TW'(cs); cfg_cs_pulse = TW'(cp); cfg_cs_hold = TW'(ch);
    cfg_cycle = CW'(cyc); cfg_byte_mode = bm;
    req_addr = addr; req_data = data; req_be = be; req_valid = 1'b1;
    chk(req_ready == 1'b1, "R1 ready idle", req_ready, 1);
    @(posedge clk);
    @(negedge clk);
    // R1: scramble timing inputs after capture; the access must not change
    cfg_we_setup = 4'd9; cfg_we_pulse = 4'd9; cfg_we_hold = 4'd9;
    cfg_cs_setup = 4'd9; cfg_cs_pulse = 4'd9; cfg_cs_hold = 4'd9;
    cfg_cycle = 6'd40; cfg_byte_mode = ~bm;
    req_valid = hv;
    req_addr = ~addr; req_data = ~data; req_be = ~be;
    for (int k = 0; k <= len + 1; k++) begin
      if (k > 0) @(negedge clk);
      if (k < len) begin
        wwin = (k >= ws) && (k < ws + pe(wp));
        cwin = (k >= cs) && (k < cs + pe(cp));
        exp_wr = bm ? ~(be & {NL{wwin}}) : '1;
        exp_bs = bm ? '1 : ~be;
        chk(mem_data_oe == 1'b1, "R2 oe", mem_data_oe, 1);
        chk(mem_addr == addr, "R2/R9 addr", mem_addr, addr);
        chk(mem_data == data, "R2 data", mem_data, data);
        chk(mem_we_n == (bm ? 1'b1 : !wwin), "R3 we_n", mem_we_n, bm ? 1'b1 : !wwin);
        chk(mem_cs_n == !cwin, "R4 cs_n", mem_cs_n, !cwin);
        chk(mem_wr_n == exp_wr, "R5 wr_n", mem_wr_n, exp_wr);
        chk(mem_bs_n == exp_bs, "R5 bs_n", mem_bs_n, exp_bs);
        chk(done == 1'b0, "R6 no early done", done, 0);
        chk(req_ready == 1'b0, "R1 busy not ready", req_ready, 0);
      end else if (k == len) begin
        chk(done == 1'b1, "R7 done at L", done, 1);
        chk(req_ready == 1'b0, "R7 ready low at L", req_ready, 0);
        chk(mem_data_oe == 1'b0, "R6 oe ends", mem_data_oe, 0);
        chk(mem_cs_n && mem_we_n && (&mem_wr_n) && (&mem_bs_n), "R8 quiet after",
            {mem_cs_n, mem_we_n, mem_wr_n, mem_bs_n}, '1);
        chk(mem_addr == addr, "R9 addr kept", mem_addr, addr);
      end else begin
        chk(done == 1'b0, "R7 done single", done, 0);
        chk(req_ready == 1'b1, "R7 ready at L+1", req_ready, 1);
      end
    end
    if (hv) begin
      @(posedge clk);
      @(negedge clk);
      req_valid = 1'b0;
      chk(mem_addr == ~addr, "R9 held request taken after done", mem_addr, ~addr);
      chk(mem_data_oe == 1'b1, "R9 second access runs", mem_data_oe, 1);
      while (!done) @(negedge clk);
      @(negedge clk);
    end
  endtask

  initial begin
    #(4 * 200000);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R8: reset state
    chk(mem_cs_n == 1'b1, "R8 cs_n reset", mem_cs_n, 1);
    chk(mem_we_n == 1'b1, "R8 we_n reset", mem_we_n, 1);
    chk(&mem_wr_n, "R8 wr_n reset", mem_wr_n, '1);
    chk(&mem_bs_n, "R8 bs_n reset", mem_bs_n, '1);
    chk(mem_data_oe == 1'b0, "R8 oe reset", mem_data_oe, 0);
    chk(done == 1'b0, "R8 done reset", done, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(req_ready == 1'b1, "R1 ready after reset", req_ready, 1);

    for (int idx = 0; idx < 729; idx++) begin
      int v, ws, wp, wh, cs, cp, ch, cyc;
      v = idx;
      ws = v % 3; v = v / 3;
      wp = v % 3; v = v / 3;
      wh = v % 3; v = v / 3;
      cs = v % 3; v = v / 3;
      cp = v % 3; v = v / 3;
      ch = v % 3;
      cyc = (idx % 3 == 0) ? 0 : ((idx % 3 == 1) ? 5 : 12);
      run_access(ws, wp, wh, cs, cp, ch, cyc, idx[1], NL'(idx * 7 + 1),
                 AW'(idx * 4099 + 17), DW'(idx * 32'h9E3779B1),
                 (idx % 61) == 0);
    end
    // R6: larger counts, cycle length dominating and being stretched
    run_access(15, 15, 15, 0, 0, 0, 3, 1'b0, 4'b1010, 24'hABCDEF, 32'h1234_5678, 1'b0);
    run_access(0, 0, 0, 7, 3, 9, 63, 1'b1, 4'b0110, 24'h000001, 32'hDEAD_BEEF, 1'b1);

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule